// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

This block controls a parameterised number of general-purpose pins from a small 32-bit register port. The pins are grouped in banks of 32, and every register array holds one word per bank. Software picks each pin's direction and sets or clears its output value. It can read the pin levels after they have been synchronised. It can also arm per-pin interrupt detection on rising edges, falling edges or an active level, with a separate polarity bit for level mode.

Each input passes through a two-flop synchroniser. It then goes through a stability filter that can be bypassed per pin. The conditioned level feeds one detector cell per pin. Edge events latch a status bit until software writes a one to clear it. In level mode the status bit tracks the active level and is never latched. The status bits are gated by a per-pin enable mask and ORed into a single interrupt line.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After a synchronous reset every register is zero. All pins are inputs (`pin_oe` low), `pin_out` is low, no status is pending and `irq` is low.
- R2: Register arrays start at these byte offsets: level 0x004, direction 0x01C, output-set 0x034, output-clear 0x04C, rising enable 0x064, falling enable 0x07C, filter bypass 0x094, interrupt enable 0x0AC, status 0x0C4, detection type 0x300, level polarity 0x318. Bank n is at base + 4*n, and pin p is bit p%32 of bank p/32. Bits above the last pin read as zero and cannot be set.
- R3: Writing a 1 to a bit at the output-set offset drives that pin's `pin_out` high. Writing a 1 at the output-clear offset drives it low. Zero bits leave the output unchanged, and no other write changes `pin_out`.
- R4: A direction bit of 1 makes the pin an output (`pin_oe` high), and 0 makes it an input. The direction array reads back as written.
- R5: The level array returns the two-flop synchronised value of `pin_in`.
- R6: In edge mode (type bit 0), a rising edge of the conditioned input sets the status bit when the rising enable is 1. A falling edge sets it when the falling enable is 1. Both enables may be on at once.
- R7: In edge mode a status bit stays set until a write of 1 to that bit at the status offset clears it. Writing 0 leaves it set.
- R8: In level mode (type bit 1), the status bit follows the active level. The level is active high when the polarity bit is 0 and active low when it is 1. Writing 1 to clear it has no lasting effect while the level stays active.
- R9: With the bypass bit at 0, a new input level reaches detection only after it has been seen in three consecutive synchronised samples, so pulses of one or two cycles are dropped. With the bypass bit at 1, the synchronised input drives detection directly.
- R10: `irq` is high exactly when some pin has both its status bit and its enable bit set.
- R11: Reads of the output-set and output-clear offsets, of gaps between arrays and of banks beyond the pin count return zero. Read data appears on `rd_data` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_PINS = 40 and the default filter depth of two. With these values the second bank is only partly populated, which exposes the padding bits, and out-of-range bank addresses fall inside the gaps between arrays. The pulse-length cases of one, two and three cycles probe the exact edge of the filter window. Pins in both banks run in edge mode and in both level polarities.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 12;
    localparam int BANK_IDX_W = 3;
    localparam int MAX_BANKS  = 6;

    typedef enum logic [3:0] {
        SEL_NONE  = 4'd0,
        SEL_LEVEL = 4'd1,
        SEL_DIR   = 4'd2,
        SEL_SET   = 4'd3,
        SEL_CLR   = 4'd4,
        SEL_RISE  = 4'd5,
        SEL_FALL  = 4'd6,
        SEL_BYP   = 4'd7,
        SEL_MASK  = 4'd8,
        SEL_STAT  = 4'd9,
        SEL_TYPE  = 4'd10,
        SEL_POL   = 4'd11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [BANK_IDX_W-1:0] bank;
    } reg_hit_t;

    function automatic int base_of(reg_sel_e s);
        case (s)
            SEL_LEVEL: return 'h004;
            SEL_DIR:   return 'h01C;
            SEL_SET:   return 'h034;
            SEL_CLR:   return 'h04C;
            SEL_RISE:  return 'h064;
            SEL_FALL:  return 'h07C;
            SEL_BYP:   return 'h094;
            SEL_MASK:  return 'h0AC;
            SEL_STAT:  return 'h0C4;
            SEL_TYPE:  return 'h300;
            SEL_POL:   return 'h318;
            default:   return -4096;
        endcase
    endfunction

    function automatic reg_hit_t decode_addr(logic [ADDR_W-1:0] a, int nbanks);
        reg_hit_t r;
        int       d;
        r.sel  = SEL_NONE;
        r.bank = '0;
        for (int k = 1; k <= 11; k++) begin
            d = int'(a) - base_of(reg_sel_e'(4'(k)));
            if (d >= 0 && d < 4 * nbanks && (d % 4) == 0) begin
                r.sel  = reg_sel_e'(4'(k));
                r.bank = BANK_IDX_W'(d / 4);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_cond.sv
module gpio_pin_cond #(
    parameter int FILT_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic bypass,
    output logic synced,
    output logic qualified
);

    logic                  meta_q;
    logic                  sync_q;
    logic [FILT_DEPTH-1:0] hist_q;
    logic                  filt_q;
    logic                  steady;

    assign steady = (hist_q == {FILT_DEPTH{sync_q}});

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= '0;
            filt_q <= 1'b0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
            hist_q <= FILT_DEPTH'({hist_q, sync_q});
            if (steady)
                filt_q <= sync_q;
        end
    end

    assign synced    = sync_q;
    assign qualified = bypass ? sync_q : filt_q;

    AST_FILT_NEEDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(hist_q) == {FILT_DEPTH{$past(sync_q)}})); // R9

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst,
    input  logic qual,
    input  logic rise_en,
    input  logic fall_en,
    input  logic lvl_mode,
    input  logic act_low,
    input  logic ack,
    output logic status
);

    logic prev_q;
    logic status_q;
    logic edge_evt;
    logic active;

    assign edge_evt = (rise_en & qual & ~prev_q) | (fall_en & ~qual & prev_q);
    assign active   = qual ^ act_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            status_q <= 1'b0;
        end else begin
            prev_q <= qual;
            if (lvl_mode)
                status_q <= active;
            else
                status_q <= edge_evt | (status_q & ~ack);
        end
    end

    assign status = status_q;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode && edge_evt) |=> status_q); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode && ack && !edge_evt) |=> !status_q); // R7

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        lvl_mode |=> (status_q == $past(active))); // R8

endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter int FILT_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int TOT_W     = NUM_BANKS * WORD_W;

    function automatic logic [TOT_W-1:0] valid_bits();
        logic [TOT_W-1:0] v;
        for (int i = 0; i < TOT_W; i++)
            v[i] = (i < NUM_PINS);
        return v;
    endfunction

    localparam logic [TOT_W-1:0] PIN_VALID = valid_bits();

    initial assert (NUM_BANKS <= MAX_BANKS);

    logic [TOT_W-1:0] dir_q, out_q, rise_q, fall_q, byp_q, mask_q, type_q, pol_q;
    logic [TOT_W-1:0] synced_w, qual_w, status_w, ack_w;
    logic [WORD_W-1:0] rd_word;
    logic [TOT_W-1:0]  rd_vec;
    reg_hit_t          hit;
    logic              wr, rd;

    assign hit = decode_addr(req_addr, NUM_BANKS);
    assign wr  = req_valid & req_write;
    assign rd  = req_valid & ~req_write;

    // Per-pin conditioning and detection
    for (genvar p = 0; p < TOT_W; p++) begin : g_pin
        if (p < NUM_PINS) begin : g_live
            gpio_pin_cond #(.FILT_DEPTH(FILT_DEPTH)) u_cond (
                .clk       (clk),
                .rst       (rst),
                .pin_raw   (pin_in[p]),
                .bypass    (byp_q[p]),
                .synced    (synced_w[p]),
                .qualified (qual_w[p])
            );
            gpio_irq_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .qual     (qual_w[p]),
                .rise_en  (rise_q[p]),
                .fall_en  (fall_q[p]),
                .lvl_mode (type_q[p]),
                .act_low  (pol_q[p]),
                .ack      (ack_w[p]),
                .status   (status_w[p])
            );
        end else begin : g_pad
            assign synced_w[p] = 1'b0;
            assign qual_w[p]   = 1'b0;
            assign status_w[p] = 1'b0;
        end
    end

    // Write-one-to-clear strobes for the status array
    always_comb begin
        ack_w = '0;
        if (wr && hit.sel == SEL_STAT) begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (hit.bank == BANK_IDX_W'(b))
                    ack_w[b*WORD_W +: WORD_W] = req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
        end
    end

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            byp_q  <= '0;
            mask_q <= '0;
            type_q <= '0;
            pol_q  <= '0;
        end else if (wr) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (hit.bank == BANK_IDX_W'(b)) begin
                    case (hit.sel)
                        SEL_DIR:  dir_q[b*WORD_W +: WORD_W]  <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        SEL_SET:  out_q[b*WORD_W +: WORD_W]  <= out_q[b*WORD_W +: WORD_W]
                                                              | (req_wdata & PIN_VALID[b*WORD_W +: WORD_W]);
                        SEL_CLR:  out_q[b*WORD_W +: WORD_W]  <= out_q[b*WORD_W +: WORD_W] & ~req_wdata;
                        SEL_RISE: rise_q[b*WORD_W +: WORD_W] <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        SEL_FALL: fall_q[b*WORD_W +: WORD_W] <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        SEL_BYP:  byp_q[b*WORD_W +: WORD_W]  <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        SEL_MASK: mask_q[b*WORD_W +: WORD_W] <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        SEL_TYPE: type_q[b*WORD_W +: WORD_W] <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        SEL_POL:  pol_q[b*WORD_W +: WORD_W]  <= req_wdata & PIN_VALID[b*WORD_W +: WORD_W];
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Read path
    always_comb begin
        case (hit.sel)
            SEL_LEVEL: rd_vec = synced_w;
            SEL_DIR:   rd_vec = dir_q;
            SEL_RISE:  rd_vec = rise_q;
            SEL_FALL:  rd_vec = fall_q;
            SEL_BYP:   rd_vec = byp_q;
            SEL_MASK:  rd_vec = mask_q;
            SEL_STAT:  rd_vec = status_w;
            SEL_TYPE:  rd_vec = type_q;
            SEL_POL:   rd_vec = pol_q;
            default:   rd_vec = '0;
        endcase
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (hit.bank == BANK_IDX_W'(b))
                rd_word = rd_vec[b*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd)
            rd_data <= rd_word;
    end

    assign pin_out = out_q[NUM_PINS-1:0];
    assign pin_oe  = dir_q[NUM_PINS-1:0];
    assign irq     = |(status_w & mask_q);

    AST_OUT_ONLY_BY_SET_CLR: assert property (@(posedge clk) disable iff (rst)
        !(wr && (hit.sel == SEL_SET || hit.sel == SEL_CLR)) |=> $stable(out_q)); // R3

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R10

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && (hit.sel == SEL_SET || hit.sel == SEL_CLR || hit.sel == SEL_NONE)) |=> (rd_data == '0)); // R11

endmodule

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;

    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr  = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gpio_banked_ctrl #(.NUM_PINS(NP)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] bank_valid(int b);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (b * 32 + i < NP);
        return m;
    endfunction

    task automatic pulse(int pin, int len);
        @(negedge clk);
        pin_in[pin] = 1'b1;
        idle(len);
        pin_in[pin] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NP-1:0] exp_out;
        logic [NP-1:0] exp_dir;
        logic [63:0] wide;
        void'($urandom(32'd2024));
        exp_out = '0;
        exp_dir = '0;

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check("R1 pin_out", 64'(pin_out), 64'h0);
        check("R1 pin_oe", 64'(pin_oe), 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
        rd_reg(12'h0C4, d); check("R1 status bank0", 64'(d), 64'h0);
        rd_reg(12'h0AC, d); check("R1 mask bank0", 64'(d), 64'h0);

        // R11: write-only and unmapped offsets read zero
        wr_reg(12'h034, 32'hFFFF_FFFF);
        rd_reg(12'h034, d); check("R11 set offset read", 64'(d), 64'h0);
        rd_reg(12'h04C, d); check("R11 clear offset read", 64'(d), 64'h0);
        rd_reg(12'h200, d); check("R11 gap read", 64'(d), 64'h0);
        rd_reg(12'h024, d); check("R11 bank beyond pins", 64'(d), 64'h0);
        wr_reg(12'h04C, 32'hFFFF_FFFF);
        wr_reg(12'h038, 32'hFFFF_FFFF);
        wr_reg(12'h050, 32'hFFFF_FFFF);

        // R2: partial bank masking
        wr_reg(12'h020, 32'hFFFF_FFFF);
        rd_reg(12'h020, d); check("R2 partial bank dir", 64'(d), 64'h0000_00FF);
        wr_reg(12'h020, 32'h0);

        // R3 R4 R2 R5: random set/clear/direction with model
        for (int it = 0; it < 150; it++) begin
            int op;
            int b;
            logic [31:0] v;
            logic [31:0] m;
            op = int'($urandom % 3);
            b  = int'($urandom % 2);
            v  = $urandom;
            m  = v & bank_valid(b);
            wide = 64'(exp_out);
            if (op == 0) begin
                wr_reg(12'(12'h034 + 4 * b), v);
                wide[b*32 +: 32] = wide[b*32 +: 32] | m;
                exp_out = wide[NP-1:0];
            end else if (op == 1) begin
                wr_reg(12'(12'h04C + 4 * b), v);
                wide[b*32 +: 32] = wide[b*32 +: 32] & ~m;
                exp_out = wide[NP-1:0];
            end else begin
                wr_reg(12'(12'h01C + 4 * b), v);
                wide = 64'(exp_dir);
                wide[b*32 +: 32] = m;
                exp_dir = wide[NP-1:0];
            end
            check("R3 pin_out model", 64'(pin_out), 64'(exp_out));
            check("R4 pin_oe model", 64'(pin_oe), 64'(exp_dir));
            if (it % 10 == 0) begin
                wide = 64'(exp_dir);
                rd_reg(12'(12'h01C + 4 * b), d);
                check("R4 R2 dir readback", 64'(d), 64'(wide[b*32 +: 32]));
                pin_in = NP'({$urandom, $urandom});
                idle(3);
                wide = 64'(pin_in);
                rd_reg(12'(12'h004 + 4 * b), d);
                check("R5 R2 level readback", 64'(d), 64'(wide[b*32 +: 32]));
            end
        end

        pin_in = '0;
        wr_reg(12'h01C, 32'h0);
        wr_reg(12'h020, 32'h0);
        idle(10);
        rd_reg(12'h0C4, d); check("R6 no status without enables", 64'(d), 64'h0);

        // R6 R7 R10: edge detection on pin 3
        wr_reg(12'h064, 32'h08);
        @(negedge clk); pin_in[3] = 1'b1;
        idle(10);
        rd_reg(12'h0C4, d); check("R6 rising edge status", 64'(d), 64'h08);
        check("R10 masked irq low", 64'(irq), 64'h0);
        wr_reg(12'h0AC, 32'h08);
        check("R10 enabled irq high", 64'(irq), 64'h1);
        wr_reg(12'h0C4, 32'h0);
        rd_reg(12'h0C4, d); check("R7 write zero keeps status", 64'(d), 64'h08);
        wr_reg(12'h0C4, 32'h08);
        rd_reg(12'h0C4, d); check("R7 w1c clears", 64'(d), 64'h0);
        check("R10 irq drops after clear", 64'(irq), 64'h0);
        @(negedge clk); pin_in[3] = 1'b0;
        idle(10);
        rd_reg(12'h0C4, d); check("R6 falling ignored when disabled", 64'(d), 64'h0);
        wr_reg(12'h07C, 32'h08);
        @(negedge clk); pin_in[3] = 1'b1;
        idle(10);
        rd_reg(12'h0C4, d); check("R6 both enabled rising", 64'(d), 64'h08);
        wr_reg(12'h0C4, 32'h08);
        @(negedge clk); pin_in[3] = 1'b0;
        idle(10);
        rd_reg(12'h0C4, d); check("R6 both enabled falling", 64'(d), 64'h08);
        wr_reg(12'h0C4, 32'h08);

        // R9: glitch filter window on pin 5
        wr_reg(12'h064, 32'h28);
        pulse(5, 1); idle(10);
        rd_reg(12'h0C4, d); check("R9 one-cycle pulse filtered", 64'(d), 64'h0);
        pulse(5, 2); idle(10);
        rd_reg(12'h0C4, d); check("R9 two-cycle pulse filtered", 64'(d), 64'h0);
        pulse(5, 3); idle(10);
        rd_reg(12'h0C4, d); check("R9 three-cycle pulse accepted", 64'(d), 64'h20);
        wr_reg(12'h0C4, 32'h20);
        wr_reg(12'h094, 32'h20);
        idle(3);
        pulse(5, 1); idle(10);
        rd_reg(12'h0C4, d); check("R9 bypass passes one-cycle pulse", 64'(d), 64'h20);
        wr_reg(12'h0C4, 32'h20);

        // R8: level mode in bank 1 (pin 36 active low, pin 37 active high)
        wr_reg(12'h31C, 32'h10);
        wr_reg(12'h304, 32'h30);
        idle(3);
        rd_reg(12'h0C8, d); check("R8 active-low level asserts", 64'(d), 64'h10);
        wr_reg(12'h0C8, 32'h10);
        rd_reg(12'h0C8, d); check("R8 clear has no lasting effect", 64'(d), 64'h10);
        wr_reg(12'h0B0, 32'h30);
        check("R10 level irq high", 64'(irq), 64'h1);
        @(negedge clk); pin_in[36] = 1'b1;
        idle(10);
        rd_reg(12'h0C8, d); check("R8 inactive level drops", 64'(d), 64'h0);
        check("R10 irq low with no status", 64'(irq), 64'h0);
        @(negedge clk); pin_in[37] = 1'b1;
        idle(10);
        rd_reg(12'h0C8, d); check("R8 active-high level asserts", 64'(d), 64'h20);
        check("R10 irq from bank1", 64'(irq), 64'h1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule